// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block models a single-clock static RAM with an 18-bit word split into two 9-bit byte lanes. Lane 0 is bits 8:0 and lane 1 is bits 17:9. The depth is set by an address-width parameter. Address, controls and write data are captured on the rising clock edge. A read returns its word through an output register one edge after the access was captured.

A burst opens when the chip is selected and either the processor strobe or the controller strobe is low. That edge loads the external address as the burst base. While the burst stays open, each cycle with no strobe makes one access at an address built from the base and a 2-bit beat counter. The counter steps only when the advance input is low. The low two address bits follow linear order (base plus count, modulo 4) when the mode input is low. They follow interleaved order (base XOR count) when the mode input is high.

Writes come from the global-write input, which covers both lanes, or from the byte-write enable combined with per-lane enables. A strobe seen while the chip enables do not all assert closes the burst in that single cycle, and the output then goes idle.

Top module: `pipe_burst_sram`

## Requirements
- R1: When the chip is selected and either strobe is low at a rising edge, the access of that edge uses the external address, and that address becomes the burst base with beat count 0.
- R2: With mode low, each later cycle that has no strobe and advance low accesses the base's upper bits joined with (base[1:0] + count) mod 4. The count rises by one per such cycle, so the fifth beat returns to the start address.
- R3: With mode high, the same cycles access the base's upper bits joined with base[1:0] XOR count, where count is 0, 1, 2, 3 and then wraps.
- R4: A cycle inside an open burst that has no strobe and advance high repeats the access at the current burst address without stepping the count.
- R5: A low processor strobe always starts a read, even when the controller strobe and the write controls are also low, and memory is left unchanged.
- R6: With global write low, both lanes are written whatever the byte-write enable and the per-lane enables say.
- R7: With global write high, lane i is written only when the byte-write enable is low and the per-lane enable bit i is low. An access with no lane enabled is a read.
- R8: Read data and a high valid flag appear at the rising edge after the edge that captured the read access. They are not present at the capturing edge itself.
- R9: The chip is selected only when enable one is low, enable two is high and enable three is low. A strobe while not selected closes the burst, so the valid flag is low one edge later and stays low until a new selected strobe.
- R10: Whenever the valid flag is low the read data is zero, and both are low from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | External word address |
| procStrbN | input | 1 | Processor burst strobe, active low, forces read |
| ctrlStrbN | input | 1 | Controller burst strobe, active low |
| advN | input | 1 | Burst advance, active low |
| allWrN | input | 1 | Global write, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | 2 | Per-lane write enables, active low, bit i for lane i |
| sel1N | input | 1 | Chip enable one, active low |
| sel2 | input | 1 | Chip enable two, active high |
| sel3N | input | 1 | Chip enable three, active low |
| burstMode | input | 1 | 0 selects linear order, 1 selects interleaved order |
| wrData | input | 18 | Write data |
| rdData | output | 18 | Registered read data, zero when not valid |
| rdValid | output | 1 | Read data valid |

## Verification
The hardest states to reach from the ports are the wrap of the 2-bit counter and the suspended burst. In both, the address in use no longer matches anything present on the pins. The stimulus opens bursts at unaligned bases (low bits 2 and 1) and runs them past four beats, so the wrap back to the base is visible in both orders. One burst is held with advance high for two cycles between steps. Each read beat is compared with a reference array that was filled with address-dependent words, so a wrong beat order shows up as wrong data.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             doRead;
    logic             doWrite;
    logic [LANES-1:0] laneWe;
  } strobe_t;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrbN,
  input  logic              ctrlStrbN,
  input  logic              advN,
  input  logic              allWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              burstMode,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] stageAddr
);
  logic              chipSel, anyStrobe, burstStart, burstClose;
  logic              burstOpen;
  logic [ADDR_W-1:0] baseAddr, effBase, accAddr;
  logic [1:0]        beatCnt, nextCnt, lowBits;
  logic [LANES-1:0]  laneMask;
  logic              wrReq, doAccess, isWrite;

  assign chipSel    = !sel1N && sel2 && !sel3N;
  assign anyStrobe  = !procStrbN || !ctrlStrbN;
  assign burstStart = chipSel && anyStrobe;
  assign burstClose = !chipSel && anyStrobe;

  assign laneMask = !allWrN ? '1 : (!byteWrEnN ? ~laneWrN : '0);
  assign wrReq    = |laneMask;

  always_comb begin
    effBase = burstStart ? addrIn : baseAddr;
    if (burstStart)  nextCnt = 2'd0;
    else if (!advN)  nextCnt = beatCnt + 2'd1;
    else             nextCnt = beatCnt;
    lowBits = burstMode ? (effBase[1:0] ^ nextCnt) : (effBase[1:0] + nextCnt);
    accAddr = {effBase[ADDR_W-1:2], lowBits};
  end

  assign doAccess = burstStart || (burstOpen && !anyStrobe);
  assign isWrite  = doAccess && wrReq && !(burstStart && !procStrbN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOpen <= 1'b0;
      baseAddr  <= '0;
      beatCnt   <= '0;
      stageAddr <= '0;
      stb       <= '0;
    end else begin
      if (burstStart)      burstOpen <= 1'b1;
      else if (burstClose) burstOpen <= 1'b0;
      if (burstStart) baseAddr <= addrIn;
      if (doAccess) begin
        beatCnt   <= nextCnt;
        stageAddr <= accAddr;
      end
      stb.doRead  <= doAccess && !isWrite;
      stb.doWrite <= isWrite;
      stb.laneWe  <= isWrite ? laneMask : '0;
    end
  end

  AST_PROC_READS: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && !procStrbN) |=> (stb.doRead && !stb.doWrite)); // R5

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && procStrbN && !ctrlStrbN && !allWrN) |=> (stb.doWrite && (&stb.laneWe))); // R6

  AST_NO_BWE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && procStrbN && !ctrlStrbN && allWrN && byteWrEnN) |=> !stb.doWrite); // R7

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (burstOpen && !anyStrobe && advN) |=> $stable(stageAddr)); // R4
endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] stageAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrDataQ <= '0;
    else       wrDataQ <= wrData;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (stb.doWrite && stb.laneWe[g])
        laneMem[stageAddr] <= wrDataQ[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[stageAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.doRead;
      rdData  <= stb.doRead ? rdWord : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0)); // R10

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRead |=> rdValid); // R8
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrbN,
  input  logic              ctrlStrbN,
  input  logic              advN,
  input  logic              allWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              sel1N,
  input  logic              sel2,
  input  logic              sel3N,
  input  logic              burstMode,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  strobe_t           stb;
  logic [ADDR_W-1:0] stageAddr;

  pbs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .allWrN(allWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N), .burstMode(burstMode),
    .stb(stb), .stageAddr(stageAddr)
  );

  pbs_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .stageAddr(stageAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((procStrbN == 1'b0 || ctrlStrbN == 1'b0) && !(!sel1N && sel2 && !sel3N))
      |=> ##1 !rdValid); // R9
endmodule

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          procStrbN = 1'b1, ctrlStrbN = 1'b1, advN = 1'b1;
  logic          allWrN = 1'b1, byteWrEnN = 1'b1;
  logic [1:0]    laneWrN = 2'b11;
  logic          sel1N = 1'b0, sel2 = 1'b1, sel3N = 1'b0;
  logic          burstMode = 1'b0;
  logic [17:0]   wrData = '0;
  logic [17:0]   rdData;
  logic          rdValid;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [17:0] refMem [1 << AW];
  logic        prevRd = 1'b0;
  logic [17:0] prevData = '0;
  string       prevTag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_burst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .procStrbN(procStrbN),
    .ctrlStrbN(ctrlStrbN), .advN(advN), .allWrN(allWrN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .sel1N(sel1N), .sel2(sel2),
    .sel3N(sel3N), .burstMode(burstMode), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [AW-1:0] burstAddr(input logic [AW-1:0] b, input int k, input bit inter);
    logic [1:0] kk;
    kk = k[1:0];
    return {b[AW-1:2], inter ? (b[1:0] ^ kk) : (b[1:0] + kk)};
  endfunction

  function automatic logic [17:0] pattern(input logic [AW-1:0] a);
    return {2'b10, a ^ 8'h5A, a};
  endfunction

  task automatic checkOut(input string tag);
    logic [17:0] expD;
    expD = prevRd ? prevData : 18'h0;
    checks++;
    if (rdValid !== prevRd || rdData !== expD) begin
      failures++;
      $display("FAIL %s: valid=%0b data=%05h expected valid=%0b data=%05h",
               tag, rdValid, rdData, prevRd, expD);
    end
  endtask

  // Drive one cycle at a negedge, pass the edge, check the previous command's output.
  task automatic step(input logic pN, input logic cN, input logic aN, input logic gN,
                      input logic bN, input logic [1:0] lN, input int selCode,
                      input logic [AW-1:0] a, input logic [17:0] d,
                      input logic expRd, input logic [AW-1:0] expAddr,
                      input logic expWr, input logic [1:0] expMask, input string tag);
    logic [17:0] snap;
    procStrbN = pN; ctrlStrbN = cN; advN = aN; allWrN = gN;
    byteWrEnN = bN; laneWrN = lN; addrIn = a; wrData = d;
    sel1N = (selCode == 1); sel2 = (selCode != 2); sel3N = (selCode == 3);
    snap = refMem[expAddr];
    if (expWr) begin
      if (expMask[0]) refMem[expAddr][8:0]  = d[8:0];
      if (expMask[1]) refMem[expAddr][17:9] = d[17:9];
    end
    @(posedge clk);
    @(negedge clk);
    checkOut(prevTag);
    prevRd = expRd; prevData = snap; prevTag = tag;
  endtask

  task automatic idle(input string tag);
    step(1, 1, 1, 1, 1, 2'b11, 1, '0, '0, 0, '0, 0, 2'b00, tag);
  endtask

  task automatic desel(input int selCode, input string tag);
    step(0, 1, 1, 1, 1, 2'b11, selCode, '0, '0, 0, '0, 0, 2'b00, tag);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] a;
      a = AW'(i);
      step(1, 0, 1, 0, 1, 2'b11, 0, a, pattern(a), 0, a, 1, 2'b11, "R6");
    end
    desel(1, "R9");
  endtask

  task automatic t_burst(input logic [AW-1:0] base, input bit inter, input string tag);
    burstMode = inter;
    step(0, 1, 1, 1, 1, 2'b11, 0, base, '0, 1, base, 0, 2'b00, "R1");
    for (int k = 1; k <= 5; k++)
      step(1, 1, 0, 1, 1, 2'b11, 0, '0, '0, 1, burstAddr(base, k, inter), 0, 2'b00, tag);
    desel(2, "R9");
    burstMode = 1'b0;
  endtask

  task automatic t_hold;
    logic [AW-1:0] b;
    b = 8'h16;
    step(0, 1, 1, 1, 1, 2'b11, 0, b, '0, 1, b, 0, 2'b00, "R1");
    step(1, 1, 1, 1, 1, 2'b11, 0, '0, '0, 1, b, 0, 2'b00, "R4");
    step(1, 1, 1, 1, 1, 2'b11, 0, '0, '0, 1, b, 0, 2'b00, "R4");
    step(1, 1, 0, 1, 1, 2'b11, 0, '0, '0, 1, burstAddr(b, 1, 0), 0, 2'b00, "R4");
    step(1, 1, 1, 1, 1, 2'b11, 0, '0, '0, 1, burstAddr(b, 1, 0), 0, 2'b00, "R4");
    desel(3, "R9");
  endtask

  task automatic t_priority;
    logic [AW-1:0] a;
    a = 8'h1C;
    step(0, 0, 1, 0, 0, 2'b00, 0, a, 18'h3FFFF, 1, a, 0, 2'b00, "R5");
    step(0, 1, 1, 1, 1, 2'b11, 0, a, '0, 1, a, 0, 2'b00, "R5");
    desel(1, "R9");
  endtask

  task automatic t_bytes;
    logic [AW-1:0] a;
    a = 8'h18;
    step(1, 0, 1, 1, 0, 2'b10, 0, a, 18'h2AAAA, 0, a, 1, 2'b01, "R7");
    step(1, 0, 1, 1, 1, 2'b00, 0, a, 18'h15555, 1, a, 0, 2'b00, "R7");
    step(0, 1, 1, 1, 1, 2'b11, 0, a, '0, 1, a, 0, 2'b00, "R7");
    step(1, 0, 1, 1, 0, 2'b01, 0, a, 18'h1E0F3, 0, a, 1, 2'b10, "R7");
    step(0, 1, 1, 1, 1, 2'b11, 0, a, '0, 1, a, 0, 2'b00, "R7");
    a = 8'h19;
    step(1, 0, 1, 0, 1, 2'b11, 0, a, 18'h0C3A5, 0, a, 1, 2'b11, "R6");
    step(0, 1, 1, 1, 1, 2'b11, 0, a, '0, 1, a, 0, 2'b00, "R6");
    desel(2, "R9");
  endtask

  task automatic t_latency;
    logic [AW-1:0] a;
    a = 8'h03;
    desel(1, "R8");
    step(0, 1, 1, 1, 1, 2'b11, 0, a, '0, 1, a, 0, 2'b00, "R8");
    desel(1, "R8");
    idle("R10");
  endtask

  task automatic t_deselect;
    step(0, 1, 1, 1, 1, 2'b11, 0, 8'h08, '0, 1, 8'h08, 0, 2'b00, "R1");
    step(1, 0, 1, 1, 1, 2'b11, 3, 8'h09, '0, 0, '0, 0, 2'b00, "R9");
    idle("R9");
    idle("R10");
    step(1, 0, 1, 1, 1, 2'b11, 0, 8'h09, '0, 1, 8'h09, 0, 2'b00, "R1");
    step(0, 1, 1, 1, 1, 2'b11, 2, 8'h0A, '0, 0, '0, 0, 2'b00, "R9");
    idle("R9");
    idle("R10");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    checks++;
    if (rdValid !== 1'b0 || rdData !== 18'h0) begin
      failures++;
      $display("FAIL R10: reset valid=%0b data=%05h expected valid=0 data=00000", rdValid, rdData);
    end
    rstN = 1'b1;
    @(negedge clk);
    t_fill();
    t_burst(8'h06, 0, "R2");
    t_burst(8'h0D, 1, "R3");
    t_hold();
    t_priority();
    t_bytes();
    t_latency();
    t_deselect();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule